// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

This block connects two processor cores that share one clock. It holds two independent one-way queues, one for each direction. Each queue is 32 bits wide and 8 words deep. Each core has its own small register port with a select, separate read and write strobes, a 2-bit address, write data and combinational read data. Through this port a core pushes words into its transmit queue, which is the queue toward the other core. It pops words from its receive queue, which is the queue from the other core. It also reads or clears a status word. Each core also has a level-sensitive interrupt line.

The register port has no handshake and never stalls. Every access is accepted or dropped in the cycle it is presented. The ready/valid flow control is carried in software-visible form. Bit 1 of the status word is the transmit-side ready: a push is accepted only while it is 1. Bit 0 is the receive-side valid: a pop returns real data only while it is 1. A push presented while ready is low, or a pop presented while valid is low, is back-pressure ignored by the sender. The block drops that access and records it in a sticky error flag, so the loss cannot go unnoticed.

Top module: `xcore_mailbox`

## Requirements
- R1: After reset both queues are empty, both sticky flags of both cores are 0, both interrupt lines are low, and a status read returns 0x00000002 on either core.
- R2: Register addresses are 0 for status (read and write), 1 for transmit data (write only) and 2 for receive data (read only). A read of address 1 or 3, or any read with the read strobe low, returns 0. Writes to addresses 2 and 3 have no effect. The read data is combinational in the access cycle.
- R3: Words pushed by one core are popped by the other core in the order they were pushed. Up to 8 words are held per direction.
- R4: A push into a full transmit queue, with no pop of that queue in the same cycle, leaves the queue unchanged and sets the pushing core's overflow flag (status bit 2).
- R5: A pop from an empty receive queue returns 0, leaves the queue unchanged and sets the popping core's underflow flag (status bit 3).
- R6: Status bit 1 (ready) is 1 exactly when the core's transmit queue holds fewer than 8 words. Status bit 0 (valid) is 1 exactly when its receive queue is not empty. Bits 31:4 read as 0.
- R7: Writing the status address clears the overflow flag if write-data bit 2 is 1, and clears the underflow flag if bit 3 is 1. Zero bits leave the flags unchanged. The ready and valid bits cannot be written. Uncleared flags stay set.
- R8: A push and a pop on the same queue in the same cycle are both honoured, even when the queue is full. The occupancy does not change and no flag is set.
- R9: Each core's interrupt is high exactly when its valid, overflow or underflow bit is 1. It follows state one clock edge after the access that changed that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_sel | input | 1 | Core 0 port select |
| c0_wr | input | 1 | Core 0 write strobe |
| c0_rd | input | 1 | Core 0 read strobe |
| c0_addr | input | 2 | Core 0 register address |
| c0_wdata | input | 32 | Core 0 write data |
| c0_rdata | output | 32 | Core 0 read data, combinational |
| c0_irq | output | 1 | Core 0 interrupt |
| c1_sel | input | 1 | Core 1 port select |
| c1_wr | input | 1 | Core 1 write strobe |
| c1_rd | input | 1 | Core 1 read strobe |
| c1_addr | input | 2 | Core 1 register address |
| c1_wdata | input | 32 | Core 1 write data |
| c1_rdata | output | 32 | Core 1 read data, combinational |
| c1_irq | output | 1 | Core 1 interrupt |

## Verification
Read data, whether status or a popped word, is due in the access cycle itself. The bench drives each access just after a falling edge and samples the read data one time unit later, before the rising edge that commits the access. Queue contents, ready/valid, sticky flags and interrupts change on that rising edge. They are therefore checked one unit after it, through the interrupt pins and through status reads in later cycles. A cycle-level model in the bench advances once per rising edge, so every expectation is taken from the model state that matches the cycle being sampled.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned FIFO_DEPTH = 8;
  localparam int unsigned ADDR_W     = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_TXDATA = 2'd1,
    REG_RXDATA = 2'd2,
    REG_SPARE  = 2'd3
  } mbox_reg_e;

  localparam int ST_VLD = 0;
  localparam int ST_RDY = 1;
  localparam int ST_WOF = 2;
  localparam int ST_ROE = 3;

  typedef struct packed {
    logic roe;
    logic wof;
    logic rdy;
    logic vld;
  } mbox_status_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             full,
  output logic             empty,
  output logic [WIDTH-1:0] head
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    level;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign pop_ok  = pop_req && !empty;
  // a full queue still accepts a push when a pop frees a slot in the same cycle
  assign push_ok = push_req && (!full || pop_ok);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic              irq,
  // transmit queue side
  input  logic              tx_full,
  input  logic              tx_push_ok,
  output logic              tx_push,
  output logic [WIDTH-1:0]  tx_data,
  // receive queue side
  input  logic              rx_empty,
  input  logic              rx_pop_ok,
  input  logic [WIDTH-1:0]  rx_head,
  output logic              rx_pop,
  // sticky flags
  output logic              wof_o,
  output logic              roe_o
);
  logic         wr_hit, rd_hit, st_wr;
  logic         wof_q, roe_q;
  mbox_status_t status;

  assign wr_hit  = sel && wr;
  assign rd_hit  = sel && rd;
  assign st_wr   = wr_hit && (mbox_reg_e'(addr) == REG_STATUS);
  assign tx_push = wr_hit && (mbox_reg_e'(addr) == REG_TXDATA);
  assign rx_pop  = rd_hit && (mbox_reg_e'(addr) == REG_RXDATA);
  assign tx_data = wdata;

  assign status = '{roe: roe_q, wof: wof_q, rdy: !tx_full, vld: !rx_empty};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wof_q <= 1'b0;
      roe_q <= 1'b0;
    end else begin
      if (tx_push && !tx_push_ok)      wof_q <= 1'b1;
      else if (st_wr && wdata[ST_WOF]) wof_q <= 1'b0;
      if (rx_pop && !rx_pop_ok)        roe_q <= 1'b1;
      else if (st_wr && wdata[ST_ROE]) roe_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (mbox_reg_e'(addr))
        REG_STATUS: rdata[$bits(mbox_status_t)-1:0] = status;
        REG_RXDATA: rdata = rx_pop_ok ? rx_head : '0;
        default:    rdata = '0;
      endcase
    end
  end

  assign irq   = status.vld | wof_q | roe_q;
  assign wof_o = wof_q;
  assign roe_o = roe_q;
endmodule

// File: rtl/xcore_mailbox.sv
module xcore_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W_P = mbox_pkg::DATA_W,
  parameter int unsigned DEPTH    = mbox_pkg::FIFO_DEPTH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                c0_sel,
  input  logic                c0_wr,
  input  logic                c0_rd,
  input  logic [ADDR_W-1:0]   c0_addr,
  input  logic [DATA_W_P-1:0] c0_wdata,
  output logic [DATA_W_P-1:0] c0_rdata,
  output logic                c0_irq,
  input  logic                c1_sel,
  input  logic                c1_wr,
  input  logic                c1_rd,
  input  logic [ADDR_W-1:0]   c1_addr,
  input  logic [DATA_W_P-1:0] c1_wdata,
  output logic [DATA_W_P-1:0] c1_rdata,
  output logic                c1_irq
);
  localparam int unsigned NCORE = 2;

  // core-indexed
  logic [NCORE-1:0]               sel_v, wr_v, rd_v, irq_v, wof_v, roe_v, c_pop;
  logic [NCORE-1:0][ADDR_W-1:0]   addr_v;
  logic [NCORE-1:0][DATA_W_P-1:0] wdata_v, rdata_v;
  // queue-indexed: queue j carries words from core j to the other core
  logic [NCORE-1:0]               f_push, f_pop, f_push_ok, f_pop_ok, f_full, f_empty;
  logic [NCORE-1:0][DATA_W_P-1:0] f_data, f_head;

  assign sel_v   = {c1_sel, c0_sel};
  assign wr_v    = {c1_wr, c0_wr};
  assign rd_v    = {c1_rd, c0_rd};
  assign addr_v  = {c1_addr, c0_addr};
  assign wdata_v = {c1_wdata, c0_wdata};
  assign c0_rdata = rdata_v[0];
  assign c1_rdata = rdata_v[1];
  assign c0_irq   = irq_v[0];
  assign c1_irq   = irq_v[1];

  // queue j is drained by the opposite core
  assign f_pop = {c_pop[0], c_pop[1]};

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    localparam int OTHER = 1 - g;

    mbox_fifo #(.WIDTH(DATA_W_P), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (f_push[g]),
      .push_data (f_data[g]),
      .pop_req   (f_pop[g]),
      .push_ok   (f_push_ok[g]),
      .pop_ok    (f_pop_ok[g]),
      .full      (f_full[g]),
      .empty     (f_empty[g]),
      .head      (f_head[g])
    );

    mbox_port #(.WIDTH(DATA_W_P)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel_v[g]),
      .wr         (wr_v[g]),
      .rd         (rd_v[g]),
      .addr       (addr_v[g]),
      .wdata      (wdata_v[g]),
      .rdata      (rdata_v[g]),
      .irq        (irq_v[g]),
      .tx_full    (f_full[g]),
      .tx_push_ok (f_push_ok[g]),
      .tx_push    (f_push[g]),
      .tx_data    (f_data[g]),
      .rx_empty   (f_empty[OTHER]),
      .rx_pop_ok  (f_pop_ok[OTHER]),
      .rx_head    (f_head[OTHER]),
      .rx_pop     (c_pop[g]),
      .wof_o      (wof_v[g]),
      .roe_o      (roe_v[g])
    );
  end
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] f_push,
  input logic [1:0] f_pop,
  input logic [1:0] f_full,
  input logic [1:0] f_empty,
  input logic [1:0] wof_v,
  input logic [1:0] roe_v,
  input logic [1:0] irq_v,
  input logic [1:0] st_wr,
  input logic [1:0] clr_wof,
  input logic [1:0] clr_roe
);
  for (genvar j = 0; j < 2; j++) begin : g_chk
    localparam int OTHER = 1 - j;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      f_full[j] |-> !f_empty[j]);

    p_drop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      f_full[j] && f_push[j] && !f_pop[j] |=> f_full[j] && wof_v[j]);

    p_drop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      f_empty[j] && f_pop[j] && !f_push[j] |=> f_empty[j] && roe_v[OTHER]);

    p_push_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      f_push[j] && f_pop[j] && !f_empty[j] |=> $stable(f_full[j]) && $stable(f_empty[j]));

    p_full_no_wof_r8: assert property (@(posedge clk) disable iff (!rst_n)
      f_full[j] && f_push[j] && f_pop[j] && !wof_v[j] |=> !wof_v[j]);

    p_wof_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wof_v[j] && !(st_wr[j] && clr_wof[j]) |=> wof_v[j]);

    p_roe_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      roe_v[j] && !(st_wr[j] && clr_roe[j]) |=> roe_v[j]);

    p_irq_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!f_empty[OTHER] || wof_v[j] || roe_v[j]) |-> irq_v[j]);

    p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (f_empty[OTHER] && !wof_v[j] && !roe_v[j]) |-> !irq_v[j]);
  end
endmodule

bind xcore_mailbox mbox_checker u_mbox_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .f_push  (f_push),
  .f_pop   (f_pop),
  .f_full  (f_full),
  .f_empty (f_empty),
  .wof_v   (wof_v),
  .roe_v   (roe_v),
  .irq_v   (irq_v),
  .st_wr   ({sel_v[1] && wr_v[1] && (addr_v[1] == 2'd0), sel_v[0] && wr_v[0] && (addr_v[0] == 2'd0)}),
  .clr_wof ({wdata_v[1][2], wdata_v[0][2]}),
  .clr_roe ({wdata_v[1][3], wdata_v[0][3]})
);

// File: tb/test_xcore_mailbox.sv
module test_xcore_mailbox;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        s_b [2];
  logic        w_b [2];
  logic        r_b [2];
  logic [1:0]  a_b [2];
  logic [31:0] d_b [2];
  logic [31:0] cap [2];
  logic [31:0] c0_rdata, c1_rdata;
  logic        c0_irq, c1_irq;

  xcore_mailbox i_xcore_mailbox (
    .clk(clk), .rst_n(rst_n),
    .c0_sel(s_b[0]), .c0_wr(w_b[0]), .c0_rd(r_b[0]), .c0_addr(a_b[0]), .c0_wdata(d_b[0]),
    .c0_rdata(c0_rdata), .c0_irq(c0_irq),
    .c1_sel(s_b[1]), .c1_wr(w_b[1]), .c1_rd(r_b[1]), .c1_addr(a_b[1]), .c1_wdata(d_b[1]),
    .c1_rdata(c1_rdata), .c1_irq(c1_irq)
  );

  // bench model: queue 0 carries core 0 -> core 1, queue 1 carries core 1 -> core 0
  logic [31:0] mq0 [$];
  logic [31:0] mq1 [$];
  bit m_wof [2];
  bit m_roe [2];
  int n_chk = 0;
  int n_fail = 0;

  function automatic int qlen(int j);
    return (j == 0) ? mq0.size() : mq1.size();
  endfunction

  function automatic logic [31:0] qfront(int j);
    return (j == 0) ? mq0[0] : mq1[0];
  endfunction

  function automatic logic [31:0] exp_status(int k);
    return {28'd0, m_roe[k], m_wof[k], qlen(k) < DEPTH, qlen(1-k) != 0};
  endfunction

  function automatic logic [31:0] exp_rdata(int k);
    if (!(s_b[k] && r_b[k])) return 32'd0;
    if (a_b[k] == 2'd0) return exp_status(k);
    if (a_b[k] == 2'd2) return (qlen(1-k) != 0) ? qfront(1-k) : 32'd0;
    return 32'd0;
  endfunction

  function automatic bit exp_irq(int k);
    return (qlen(1-k) != 0) || m_wof[k] || m_roe[k];
  endfunction

  function automatic void model_update();
    for (int j = 0; j < 2; j++) begin
      bit push, pop, pop_ok, push_ok;
      push = s_b[j] && w_b[j] && (a_b[j] == 2'd1);
      pop  = s_b[1-j] && r_b[1-j] && (a_b[1-j] == 2'd2);
      pop_ok  = pop && (qlen(j) > 0);
      push_ok = push && ((qlen(j) < DEPTH) || pop_ok);
      if (j == 0) begin
        if (pop_ok)  void'(mq0.pop_front());
        if (push_ok) mq0.push_back(d_b[j]);
      end else begin
        if (pop_ok)  void'(mq1.pop_front());
        if (push_ok) mq1.push_back(d_b[j]);
      end
      if (push && !push_ok) m_wof[j] = 1'b1;
      if (pop && !pop_ok)   m_roe[1-j] = 1'b1;
    end
    for (int k = 0; k < 2; k++) begin
      if (s_b[k] && w_b[k] && (a_b[k] == 2'd0)) begin
        if (d_b[k][2]) m_wof[k] = 1'b0;
        if (d_b[k][3]) m_roe[k] = 1'b0;
      end
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_all();
    for (int k = 0; k < 2; k++) begin
      s_b[k] = 1'b0; w_b[k] = 1'b0; r_b[k] = 1'b0; a_b[k] = 2'd0; d_b[k] = 32'd0;
    end
  endtask

  task automatic set_op(input int k, input bit w, input bit r, input logic [1:0] a, input logic [31:0] d);
    s_b[k] = 1'b1; w_b[k] = w; r_b[k] = r; a_b[k] = a; d_b[k] = d;
  endtask

  // ops are staged with set_op before calling; applied just after a falling edge
  task automatic run_cycle();
    logic [31:0] e [2];
    #1;
    cap[0] = c0_rdata;
    cap[1] = c1_rdata;
    for (int k = 0; k < 2; k++) begin
      e[k] = exp_rdata(k);
      if (s_b[k] && r_b[k])
        chk(cap[k] === e[k], (a_b[k] == 2'd2) ? "R3 pop data" : "R2 read data", cap[k], e[k]);
    end
    model_update();
    @(posedge clk);
    #1;
    chk(c0_irq === exp_irq(0), "R9 irq core0", {31'd0, c0_irq}, {31'd0, exp_irq(0)});
    chk(c1_irq === exp_irq(1), "R9 irq core1", {31'd0, c1_irq}, {31'd0, exp_irq(1)});
    @(negedge clk);
    idle_all();
  endtask

  task automatic read_status(input int k);
    set_op(k, 1'b0, 1'b1, 2'd0, 32'd0);
    run_cycle();
  endtask

  bit done = 1'b0;

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(c0_irq === 1'b0 && c1_irq === 1'b0, "R1 irq low after reset", {c1_irq, c0_irq}, 32'd0);
    read_status(0); chk(cap[0] === 32'h2, "R1 status core0", cap[0], 32'h2);
    read_status(1); chk(cap[1] === 32'h2, "R1 status core1", cap[1], 32'h2);

    // R3/R6 fill core0 transmit queue
    for (int i = 0; i < DEPTH; i++) begin
      set_op(0, 1'b1, 1'b0, 2'd1, 32'h100 + i);
      run_cycle();
    end
    read_status(0); chk(cap[0] === 32'h0, "R6 core0 ready low when full", cap[0], 32'h0);
    read_status(1); chk(cap[1] === 32'h3, "R6 core1 valid and ready", cap[1], 32'h3);

    // R4 push while full
    set_op(0, 1'b1, 1'b0, 2'd1, 32'hDEAD);
    run_cycle();
    read_status(0); chk(cap[0] === 32'h4, "R4 overflow flag set", cap[0], 32'h4);
    chk(c0_irq === 1'b1, "R9 irq from overflow", {31'd0, c0_irq}, 32'd1);

    // R7 write-one-to-clear
    set_op(0, 1'b1, 1'b0, 2'd0, 32'h3);
    run_cycle();
    read_status(0); chk(cap[0] === 32'h4, "R7 zero bits keep flag", cap[0], 32'h4);
    set_op(0, 1'b1, 1'b0, 2'd0, 32'h4);
    run_cycle();
    read_status(0); chk(cap[0] === 32'h0, "R7 one clears overflow", cap[0], 32'h0);

    // R8 push and pop together on a full queue
    set_op(0, 1'b1, 1'b0, 2'd1, 32'hAA);
    set_op(1, 1'b0, 1'b1, 2'd2, 32'd0);
    run_cycle();
    chk(cap[1] === 32'h100, "R8 pop oldest during push", cap[1], 32'h100);
    read_status(0); chk(cap[0] === 32'h0, "R8 still full, no overflow", cap[0], 32'h0);

    // R3 drain in order
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] want;
      want = (i < DEPTH - 1) ? 32'h101 + i : 32'hAA;
      set_op(1, 1'b0, 1'b1, 2'd2, 32'd0);
      run_cycle();
      chk(cap[1] === want, "R3 order", cap[1], want);
    end

    // R5 pop empty
    set_op(1, 1'b0, 1'b1, 2'd2, 32'd0);
    run_cycle();
    chk(cap[1] === 32'h0, "R5 empty pop returns zero", cap[1], 32'h0);
    read_status(1); chk(cap[1] === 32'hA, "R5 underflow flag set", cap[1], 32'hA);
    set_op(1, 1'b1, 1'b0, 2'd0, 32'h8);
    run_cycle();
    chk(c1_irq === 1'b0, "R9 irq low after clear", {31'd0, c1_irq}, 32'd0);

    // R2 unused address and wrong-direction accesses
    set_op(0, 1'b1, 1'b1, 2'd3, 32'h55);
    run_cycle();
    chk(cap[0] === 32'h0, "R2 spare reads zero", cap[0], 32'h0);
    set_op(0, 1'b1, 1'b0, 2'd2, 32'h77);
    run_cycle();
    set_op(0, 1'b0, 1'b1, 2'd1, 32'd0);
    run_cycle();
    chk(cap[0] === 32'h0, "R2 tx address reads zero", cap[0], 32'h0);
    read_status(1); chk(cap[1] === 32'h2, "R2 writes to 2/3 ignored", cap[1], 32'h2);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit hold;
      hold = ((i / 300) % 2) == 1;
      for (int k = 0; k < 2; k++) begin
        if ($urandom % 4 != 0) begin
          logic [1:0] a;
          a = 2'($urandom % 4);
          if (hold && a == 2'd2) a = 2'd1;
          set_op(k, 1'($urandom % 2), 1'($urandom % 2), a,
                 (a == 2'd0 && $urandom % 4 != 0) ? 32'd0 : $urandom);
        end
      end
      run_cycle();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule